// File: doc/BRIEF.md
# Direct-Mapped Write-Back Cache with Early Restart

This block sits between a processor and main memory. It holds 128 lines of sixteen 16-bit words each, and every memory block has exactly one line it can occupy. The processor presents a request on a read/write port and keeps it asserted until `cpu_ready` is high. A hit is served in the same cycle. A miss stalls the processor while the block refills the line from memory over a word-at-a-time handshake.

Refill always starts at word 0 and runs in order. The word the processor asked for is handed over in the cycle memory delivers it, so the processor does not wait for the rest of the line. Writes are kept in the cache and mark the line dirty. A dirty line goes back to memory only when another block claims its slot, and that write-back happens before the refill. A write miss brings the line in first and then merges the write into it.

Top module: `er_dmcache`

## Requirements
- R1: The 16-bit word address splits into offset = bits [3:0], line index = bits [10:4] and tag = bits [15:11]. A block can live only in the line named by its index (block number mod 128).
- R2: A request is a hit when the indexed line is valid and its stored tag equals the address tag. A read hit raises `cpu_ready` in the same cycle with the word on `cpu_rdata` and causes no memory traffic.
- R3: Reset clears every valid bit, so the first access to any line misses, even for tag 0. In reset `cpu_ready` and `mem_req` are low.
- R4: A refill issues 16 reads (`mem_we` = 0) to {tag, index, 0..15}, in order from word 0, one word per `mem_ack`. Once the last word arrives the line is valid with the new tag, and the next cycle has `mem_req` low.
- R5: During a refill, `cpu_ready` rises in the cycle where `mem_ack` delivers the requested word, and `cpu_rdata` then equals `mem_rdata`. Words that come before it do not release the processor.
- R6: A write hit updates only the cached word and sets the line dirty. It causes no memory transfer.
- R7: A write miss refills the line as a read miss does, then holds the written value in the line. The line is dirty afterwards.
- R8: Before refilling a line that is both valid and dirty, the block writes its 16 words (`mem_we` = 1) to the old address {old tag, index, 0..15}, in order from word 0, carrying the current cached data. A clean victim is not written back.
- R9: From the early handover until the last refill word arrives, no new request is served. `cpu_ready` is high while `mem_req` is high only in the handover cycle itself.
- R10: Two blocks with the same index and different tags evict each other, so alternating between them misses on every access.
- R11: While `mem_req` is high and `mem_ack` is low, `mem_addr`, `mem_we` and `mem_wdata` hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Processor request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 16 | Word address |
| cpu_wdata | input | 16 | Write data |
| cpu_ready | output | 1 | Request served this cycle |
| cpu_rdata | output | 16 | Read data, valid with `cpu_ready` |
| mem_req | output | 1 | Memory transfer requested |
| mem_we | output | 1 | 1 = write-back word, 0 = refill word |
| mem_addr | output | 16 | Word address of the transfer |
| mem_wdata | output | 16 | Write-back data |
| mem_ack | input | 1 | Current word transferred this cycle |
| mem_rdata | input | 16 | Refill data, valid with `mem_ack` |

## Verification
Two functions can fall in the same cycle: the early handover of the requested word, and the refill write of that same word into the data array. With a write miss they also meet the merge of the processor's data. The bench places requested words at offset 0, in the middle of the line and at offset 15, where the handover coincides with the line becoming valid. It then issues a hit to the same line at once. The reference model judges the result by the handover cycle, the forwarded value, the absence of any service before the last refill word, and the value a later read returns.

// File: rtl/er_cache_pkg.sv
package er_cache_pkg;
   // Controller phases: serve hits, write back a dirty victim,
   // refill before handover, refill after handover
   typedef enum logic [1:0] {
      PH_LOOKUP = 2'd0,
      PH_EVICT  = 2'd1,
      PH_FETCH  = 2'd2,
      PH_DRAIN  = 2'd3
   } phase_t;
endpackage

// File: rtl/er_tag_store.sv
module er_tag_store #(
   parameter int TAG_W = 5,
   parameter int IDX_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] rd_idx,
   output logic [TAG_W-1:0] rd_tag,
   output logic             rd_valid,
   output logic             rd_dirty,
   input  logic             fill_en,
   input  logic [IDX_W-1:0] fill_idx,
   input  logic [TAG_W-1:0] fill_tag,
   input  logic             fill_dirty,
   input  logic             mark_en,
   input  logic [IDX_W-1:0] mark_idx
);
   localparam int LINES = 1 << IDX_W;

   logic [TAG_W-1:0] tags [LINES];
   logic [LINES-1:0] vld_vec;
   logic [LINES-1:0] drt_vec;

   always_ff @(posedge clk) begin
      if (fill_en) tags[fill_idx] <= fill_tag;
   end

   for (genvar g = 0; g < LINES; g++) begin : g_line
      localparam logic [IDX_W-1:0] LINE_ID = IDX_W'(g);
      logic v_q;
      logic d_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            v_q <= 1'b0;
            d_q <= 1'b0;
         end else if (fill_en && (fill_idx == LINE_ID)) begin
            v_q <= 1'b1;
            d_q <= fill_dirty;
         end else if (mark_en && (mark_idx == LINE_ID)) begin
            d_q <= 1'b1;
         end
      end
      assign vld_vec[g] = v_q;
      assign drt_vec[g] = d_q;
   end

   assign rd_tag   = tags[rd_idx];
   assign rd_valid = vld_vec[rd_idx];
   assign rd_dirty = drt_vec[rd_idx];
endmodule

// File: rtl/er_data_store.sv
module er_data_store #(
   parameter int DATA_W = 16,
   parameter int AW     = 11
) (
   input  logic              clk,
   input  logic [AW-1:0]     rd_addr,
   output logic [DATA_W-1:0] rd_data,
   input  logic              wr_en,
   input  logic [AW-1:0]     wr_addr,
   input  logic [DATA_W-1:0] wr_data
);
   localparam int DEPTH = 1 << AW;

   logic [DATA_W-1:0] words [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en) words[wr_addr] <= wr_data;
   end

   assign rd_data = words[rd_addr];
endmodule

// File: rtl/er_fill_ctrl.sv
module er_fill_ctrl
   import er_cache_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int OFF_W  = 4,
   parameter int IDX_W  = 7,
   parameter int DATA_W = 16
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      cpu_req,
   input  logic                      cpu_we,
   input  logic [ADDR_W-1:0]         cpu_addr,
   input  logic [DATA_W-1:0]         cpu_wdata,
   output logic                      cpu_ready,
   output logic [DATA_W-1:0]         cpu_rdata,
   output logic                      mem_req,
   output logic                      mem_we,
   output logic [ADDR_W-1:0]         mem_addr,
   output logic [DATA_W-1:0]         mem_wdata,
   input  logic                      mem_ack,
   input  logic [DATA_W-1:0]         mem_rdata,
   output logic [IDX_W-1:0]          lk_idx,
   input  logic [ADDR_W-IDX_W-OFF_W-1:0] lk_tag,
   input  logic                      lk_valid,
   input  logic                      lk_dirty,
   output logic                      fill_en,
   output logic [ADDR_W-IDX_W-OFF_W-1:0] fill_tag,
   output logic                      fill_dirty,
   output logic                      mark_en,
   output logic [IDX_W+OFF_W-1:0]    dat_ra,
   input  logic [DATA_W-1:0]         dat_rd,
   output logic                      dat_we,
   output logic [IDX_W+OFF_W-1:0]    dat_wa,
   output logic [DATA_W-1:0]         dat_wd
);
   localparam int TAG_W = ADDR_W - IDX_W - OFF_W;

   // R1: address fields
   logic [OFF_W-1:0] c_off;
   logic [IDX_W-1:0] c_idx;
   logic [TAG_W-1:0] c_tag;
   assign c_off = cpu_addr[OFF_W-1:0];
   assign c_idx = cpu_addr[OFF_W +: IDX_W];
   assign c_tag = cpu_addr[ADDR_W-1 -: TAG_W];

   phase_t            ph_q, ph_d;
   logic [OFF_W-1:0]  cnt_q;
   logic [TAG_W-1:0]  l_tag;
   logic [IDX_W-1:0]  l_idx;
   logic [OFF_W-1:0]  l_off;
   logic              l_we;
   logic [DATA_W-1:0] l_wdata;

   logic hit;
   logic last_word;
   logic at_req_word;

   assign lk_idx      = (ph_q == PH_LOOKUP) ? c_idx : l_idx;
   assign hit         = lk_valid && (lk_tag == c_tag);
   assign last_word   = (cnt_q == {OFF_W{1'b1}});
   assign at_req_word = (cnt_q == l_off);
   assign dat_ra      = (ph_q == PH_LOOKUP) ? {c_idx, c_off} : {l_idx, cnt_q};
   assign fill_tag    = l_tag;
   assign fill_dirty  = l_we;

   always_comb begin
      ph_d      = ph_q;
      cpu_ready = 1'b0;
      cpu_rdata = dat_rd;
      mem_req   = 1'b0;
      mem_we    = 1'b0;
      mem_addr  = {l_tag, l_idx, cnt_q};
      mem_wdata = dat_rd;
      dat_we    = 1'b0;
      dat_wa    = {c_idx, c_off};
      dat_wd    = cpu_wdata;
      mark_en   = 1'b0;
      fill_en   = 1'b0;
      unique case (ph_q)
         PH_LOOKUP: begin
            if (cpu_req) begin
               if (hit) begin
                  cpu_ready = 1'b1;
                  if (cpu_we) begin
                     dat_we  = 1'b1;
                     mark_en = 1'b1;
                  end
               end else begin
                  ph_d = (lk_valid && lk_dirty) ? PH_EVICT : PH_FETCH;
               end
            end
         end
         PH_EVICT: begin
            mem_req  = 1'b1;
            mem_we   = 1'b1;
            mem_addr = {lk_tag, l_idx, cnt_q};
            if (mem_ack && last_word) ph_d = PH_FETCH;
         end
         PH_FETCH, PH_DRAIN: begin
            mem_req = 1'b1;
            dat_wa  = {l_idx, cnt_q};
            dat_wd  = (ph_q == PH_FETCH && l_we && at_req_word) ? l_wdata : mem_rdata;
            if (mem_ack) begin
               dat_we = 1'b1;
               if (ph_q == PH_FETCH && at_req_word) begin
                  cpu_ready = 1'b1;
                  cpu_rdata = mem_rdata;
                  ph_d      = PH_DRAIN;
               end
               if (last_word) begin
                  fill_en = 1'b1;
                  ph_d    = PH_LOOKUP;
               end
            end
         end
         default: ph_d = PH_LOOKUP;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q    <= PH_LOOKUP;
         cnt_q   <= '0;
         l_tag   <= '0;
         l_idx   <= '0;
         l_off   <= '0;
         l_we    <= 1'b0;
         l_wdata <= '0;
      end else begin
         ph_q <= ph_d;
         if (ph_q == PH_LOOKUP) begin
            cnt_q <= '0;
            if (cpu_req && !hit) begin
               l_tag   <= c_tag;
               l_idx   <= c_idx;
               l_off   <= c_off;
               l_we    <= cpu_we;
               l_wdata <= cpu_wdata;
            end
         end else if (mem_ack) begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end
endmodule

// File: rtl/er_dmcache.sv
module er_dmcache #(
   parameter int ADDR_W = 16,
   parameter int OFF_W  = 4,
   parameter int IDX_W  = 7,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_req,
   input  logic              cpu_we,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [DATA_W-1:0] cpu_wdata,
   output logic              cpu_ready,
   output logic [DATA_W-1:0] cpu_rdata,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic              mem_ack,
   input  logic [DATA_W-1:0] mem_rdata
);
   localparam int TAG_W = ADDR_W - IDX_W - OFF_W;
   localparam int DAW   = IDX_W + OFF_W;

   if (TAG_W < 1) begin : g_chk_tag
      $error("er_dmcache: address too narrow for index and offset");
   end
   if (OFF_W < 1 || IDX_W < 1) begin : g_chk_geom
      $error("er_dmcache: offset and index need at least one bit");
   end
   if (DATA_W < 1) begin : g_chk_data
      $error("er_dmcache: word width must be positive");
   end

   logic [IDX_W-1:0]  lk_idx;
   logic [TAG_W-1:0]  lk_tag;
   logic              lk_valid, lk_dirty;
   logic              fill_en, fill_dirty, mark_en;
   logic [TAG_W-1:0]  fill_tag;
   logic [DAW-1:0]    dat_ra, dat_wa;
   logic [DATA_W-1:0] dat_rd, dat_wd;
   logic              dat_we;

   er_tag_store #(.TAG_W(TAG_W), .IDX_W(IDX_W)) u_tags (
      .clk(clk), .rst_n(rst_n),
      .rd_idx(lk_idx), .rd_tag(lk_tag), .rd_valid(lk_valid), .rd_dirty(lk_dirty),
      .fill_en(fill_en), .fill_idx(lk_idx), .fill_tag(fill_tag), .fill_dirty(fill_dirty),
      .mark_en(mark_en), .mark_idx(lk_idx)
   );

   er_data_store #(.DATA_W(DATA_W), .AW(DAW)) u_data (
      .clk(clk), .rd_addr(dat_ra), .rd_data(dat_rd),
      .wr_en(dat_we), .wr_addr(dat_wa), .wr_data(dat_wd)
   );

   er_fill_ctrl #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n),
      .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
      .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_ack(mem_ack), .mem_rdata(mem_rdata),
      .lk_idx(lk_idx), .lk_tag(lk_tag), .lk_valid(lk_valid), .lk_dirty(lk_dirty),
      .fill_en(fill_en), .fill_tag(fill_tag), .fill_dirty(fill_dirty), .mark_en(mark_en),
      .dat_ra(dat_ra), .dat_rd(dat_rd), .dat_we(dat_we), .dat_wa(dat_wa), .dat_wd(dat_wd)
   );
endmodule

// File: rtl/er_dmcache_chk.sv
module er_dmcache_chk #(
   parameter int ADDR_W = 16,
   parameter int OFF_W  = 4,
   parameter int IDX_W  = 7,
   parameter int DATA_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cpu_ready,
   input logic              mem_req,
   input logic              mem_we,
   input logic              mem_ack,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [DATA_W-1:0] mem_wdata
);
   a_r11_hold_while_waiting: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

   a_r4_fill_in_order: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_we && mem_ack && (mem_addr[OFF_W-1:0] != {OFF_W{1'b1}})
      |=> mem_req && !mem_we && (mem_addr == ADDR_W'($past(mem_addr) + 1'b1)));

   a_r4_fill_end_idle: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_we && mem_ack && (mem_addr[OFF_W-1:0] == {OFF_W{1'b1}}) |=> !mem_req);

   a_r8_evict_in_order: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && mem_we && mem_ack && (mem_addr[OFF_W-1:0] != {OFF_W{1'b1}})
      |=> mem_req && mem_we && (mem_addr == ADDR_W'($past(mem_addr) + 1'b1)));

   a_r8_evict_then_fill: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && mem_we && mem_ack && (mem_addr[OFF_W-1:0] == {OFF_W{1'b1}})
      |=> mem_req && !mem_we && (mem_addr[OFF_W-1:0] == {OFF_W{1'b0}})
          && (mem_addr[OFF_W +: IDX_W] == $past(mem_addr[OFF_W +: IDX_W])));

   a_r9_ready_only_at_handover: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_ready && mem_req |-> mem_ack && !mem_we);
endmodule

bind er_dmcache er_dmcache_chk #(
   .ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W), .DATA_W(DATA_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .cpu_ready(cpu_ready), .mem_req(mem_req),
   .mem_we(mem_we), .mem_ack(mem_ack), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
);

// File: tb/er_dmcache_bench.sv
module er_dmcache_bench;
   localparam int PERIOD = 10;
   localparam int QTR    = PERIOD / 4;

   typedef struct {
      logic        we;
      logic [15:0] addr;
      logic [15:0] data;
   } xfer_t;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        cpu_req, cpu_we;
   logic [15:0] cpu_addr, cpu_wdata;
   logic        cpu_ready;
   logic [15:0] cpu_rdata;
   logic        mem_req, mem_we;
   logic [15:0] mem_addr, mem_wdata;
   logic        mem_ack;
   logic [15:0] mem_rdata;

   er_dmcache u_er_dmcache (
      .clk(clk), .rst_n(rst_n),
      .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
      .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_ack(mem_ack), .mem_rdata(mem_rdata)
   );

   always #(PERIOD/2) clk = ~clk;

   // Reference model: processor view, backing memory, line directory
   logic [15:0] ref_mem [65536];
   logic [15:0] mem_img [65536];
   logic [4:0]  rt   [128];
   bit          rv   [128];
   bit          rdty [128];
   xfer_t       exp_q [$];
   int          n_chk = 0;
   int          n_fail = 0;
   int          mem_lat = 0;
   int unsigned seed = 32'd7;
   bit          finished = 0;

   task automatic chk(input bit ok, input string rq, input string what,
                      input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: %s actual=0x%0h expected=0x%0h", rq, what, act, exp);
      end
   endtask

   // Memory responder with configurable wait states
   initial begin
      int wcnt;
      xfer_t e;
      wcnt = 0;
      mem_ack = 1'b0;
      mem_rdata = '0;
      forever begin
         @(negedge clk);
         mem_ack = 1'b0;
         if (rst_n === 1'b1 && mem_req === 1'b1) begin
            if (wcnt >= mem_lat) begin
               wcnt = 0;
               mem_ack = 1'b1;
               if (exp_q.size() == 0) begin
                  chk(0, "R4", "unexpected memory transfer", int'(mem_addr), 0);
               end else begin
                  e = exp_q.pop_front();
                  chk(mem_we == e.we && mem_addr == e.addr, e.we ? "R8" : "R4",
                      "transfer kind/address", int'({mem_we, mem_addr}), int'({e.we, e.addr}));
                  if (mem_we) begin
                     chk(mem_wdata == e.data, "R8", "write-back data", int'(mem_wdata), int'(e.data));
                     mem_img[mem_addr] = mem_wdata;
                  end else begin
                     mem_rdata = mem_img[mem_addr];
                  end
               end
            end else begin
               wcnt++;
            end
         end else begin
            wcnt = 0;
         end
      end
   end

   task automatic do_op(input bit we, input logic [15:0] a, input logic [15:0] d, input string rq);
      // R1: field split of the word address
      logic [6:0]  idx;
      logic [4:0]  tg;
      bit          exp_hit;
      logic [15:0] exp_d;
      bit          done;
      int          n;
      idx = a[10:4];
      tg  = a[15:11];
      exp_hit = rv[idx] && (rt[idx] == tg);
      if (!exp_hit) begin
         if (rv[idx] && rdty[idx]) begin
            for (int w = 0; w < 16; w++) begin
               xfer_t x;
               x.we = 1'b1; x.addr = {rt[idx], idx, 4'(w)}; x.data = ref_mem[{rt[idx], idx, 4'(w)}];
               exp_q.push_back(x);
            end
         end
         for (int w = 0; w < 16; w++) begin
            xfer_t x;
            x.we = 1'b0; x.addr = {tg, idx, 4'(w)}; x.data = '0;
            exp_q.push_back(x);
         end
         rv[idx] = 1; rt[idx] = tg; rdty[idx] = 0;
      end
      exp_d = ref_mem[a];
      if (we) begin
         rdty[idx] = 1;
         ref_mem[a] = d;
      end
      @(negedge clk);
      cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
      done = 0; n = 0;
      while (!done) begin
         #(QTR);
         if (cpu_ready && mem_req && !(mem_ack && !mem_we && mem_addr == a))
            chk(0, "R9", "served during refill", int'(mem_addr), int'(a));
         if (cpu_ready) begin
            if (!mem_req)
               chk(exp_hit, exp_hit ? "R2" : "R3", "served without refill (hit?)", 1, int'(exp_hit));
            else
               chk(!exp_hit && mem_addr == a, "R5", "handover word address", int'(mem_addr), int'(a));
            if (!we) chk(cpu_rdata == exp_d, rq, "read data", int'(cpu_rdata), int'(exp_d));
            done = 1;
         end else begin
            if (exp_hit && !mem_req) chk(0, "R2", "hit not served", 0, 1);
            n++;
            if (n > 3000) begin
               chk(0, rq, "op timeout", n, 0);
               done = 1;
            end else begin
               @(negedge clk);
            end
         end
      end
   endtask

   task automatic go_idle(input int cycles);
      @(negedge clk);
      cpu_req = 1'b0;
      repeat (cycles) @(negedge clk);
   endtask

   initial begin
      for (int i = 0; i < 65536; i++) begin
         ref_mem[i] = 16'(i * 40503) ^ 16'h5a5a;
         mem_img[i] = ref_mem[i];
      end
      for (int i = 0; i < 128; i++) begin
         rv[i] = 0; rdty[i] = 0; rt[i] = '0;
      end
      rst_n = 1'b0; cpu_req = 1'b0; cpu_we = 1'b0; cpu_addr = '0; cpu_wdata = '0;
      repeat (3) @(negedge clk);
      #(QTR);
      chk(cpu_ready == 1'b0, "R3", "ready in reset", int'(cpu_ready), 0);
      chk(mem_req == 1'b0, "R3", "mem_req in reset", int'(mem_req), 0);
      @(negedge clk);
      rst_n = 1'b1;

      mem_lat = 1;
      do_op(0, 16'h0000, 0, "R3");        // tag 0 still misses after reset
      do_op(0, 16'h0005, 0, "R2");        // hit in the filled line
      mem_lat = 2;
      do_op(0, 16'h003A, 0, "R5");        // handover at word 10
      do_op(0, 16'h0031, 0, "R9");        // hit held off until refill ends
      do_op(1, 16'h0007, 16'hBEEF, "R6"); // write hit, no traffic
      do_op(0, 16'h0007, 0, "R6");
      mem_lat = 0;
      do_op(0, 16'h0807, 0, "R8");        // dirty victim written back (R10 conflict)
      do_op(0, 16'h0007, 0, "R10");       // evicts again, clean victim
      do_op(0, 16'h0807, 0, "R10");
      do_op(1, 16'h1234, 16'hCAFE, "R7"); // write miss allocates
      do_op(0, 16'h1234, 0, "R7");
      do_op(0, 16'h1A34, 0, "R8");        // evicts the dirty line
      do_op(0, 16'h1234, 0, "R7");
      mem_lat = 1;
      do_op(1, 16'h20FF, 16'h1111, "R5"); // handover at last word
      do_op(0, 16'h20F0, 0, "R4");
      go_idle(3);

      for (int i = 0; i < 120; i++) begin
         logic [15:0] a;
         bit we;
         seed = seed * 32'd1103515245 + 32'd12345;
         a = {3'b000, seed[17:16], 4'b0000, seed[21:19], seed[27:24]};
         we = seed[30];
         mem_lat = i % 3;
         do_op(we, a, seed[15:0] ^ 16'h00FF, we ? "R7" : "R2");
         if (seed[29]) go_idle(1);
      end
      go_idle(60);
      chk(exp_q.size() == 0, "R4", "pending memory transfers", exp_q.size(), 0);
      if (!finished) begin
         finished = 1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         chk(0, "R4", "watchdog expired", 0, 1);
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule